// File: doc/BRIEF.md
# SCSI Initiator Register File

This block is the processor-side register file of a SCSI bus initiator. A 3-bit address selects one of eight byte registers. Writes to the initiator command register drive the SCSI control lines RST, ACK, BSY, SEL and ATN. The same register turns the output data byte onto the data bus. Reads return the live bus lines and the block's own DMA and phase state.

The expected phase is held in the target command register. It is compared against the MSG, C/D and I/O lines in every cycle. While DMA mode is on, losing BSY or losing phase match ends DMA by itself: the DMA bit is cleared, an end-of-DMA flag is raised and DRQ is dropped.

Arbitration and byte handshaking belong to neighbouring blocks. They reach this block through the arbitration status inputs, the DRQ set/clear inputs, the DMA start pulses and the mode register output. Parity, interrupt and target-mode status bits read as zero.

Top module: `scsi_ini_regfile`

## Requirements
- R1: A synchronous reset clears every register, releases all driven SCSI lines (drive outputs 0, data 0) and deasserts DRQ.
- R2: A write to address 1 stores bits 7,4,3,2,1,0, which drive RST, ACK, BSY, SEL, ATN and data-enable from the next cycle. Reading address 1 returns those bits, with bit6 = arb_busy_in and bit5 = arb_lost_in.
- R3: drv_data equals the output data register (address 0 write) whenever data-enable is set, and is 0 otherwise. A write to either register is seen on drv_data from the next cycle.
- R4: Reading address 0 returns bus_data_in.
- R5: Reading address 4 returns {RST,BSY,REQ,MSG,C/D,I/O,SEL,0}, from bit7 down to bit0, all taken from the live inputs.
- R6: Reading address 5 returns {end-of-DMA, DRQ, 0, 0, phase match, 0, ATN, ACK}, from bit7 down to bit0, with ATN and ACK live.
- R7: Phase match is 1 exactly when {MSG,C/D,I/O} equals bits 2:0 of the target command register (address 3), and it follows both in the same cycle.
- R8: While mode bit1 (DMA) is set, BSY low or phase mismatch clears mode bit1 at the next edge, sets end-of-DMA and clears DRQ.
- R9: A write to address 2 clears end-of-DMA. If the DMA end of R8 happens in the same cycle, end-of-DMA is set and mode bit1 is cleared while the other written bits are kept.
- R10: DRQ is set by drq_set_in or by a write to address 5, and is cleared by drq_clr_in or by a DMA end. A clear wins over a set in the same cycle.
- R11: Writes to addresses 5, 6 and 7 each give a one-cycle pulse on dma_send_go, dma_trecv_go and dma_irecv_go respectively, in the cycle after the write.
- R12: Reads of addresses 6 and 7 return 0. A write to address 4 changes no register and no output.
- R13: The mode (address 2) and target command (address 3) registers read back the full byte last written, apart from the mode bit1 clearing of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 3 | Register select |
| cpu_we | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for cpu_addr |
| bus_data_in | input | 8 | Sampled SCSI data bus |
| bus_rst_in | input | 1 | Sampled RST |
| bus_bsy_in | input | 1 | Sampled BSY |
| bus_req_in | input | 1 | Sampled REQ |
| bus_msg_in | input | 1 | Sampled MSG |
| bus_cd_in | input | 1 | Sampled C/D |
| bus_io_in | input | 1 | Sampled I/O |
| bus_sel_in | input | 1 | Sampled SEL |
| bus_atn_in | input | 1 | Sampled ATN |
| bus_ack_in | input | 1 | Sampled ACK |
| arb_busy_in | input | 1 | Arbitration in progress, from arbitration block |
| arb_lost_in | input | 1 | Arbitration lost, from arbitration block |
| drq_set_in | input | 1 | Request DRQ, from handshake block |
| drq_clr_in | input | 1 | Drop DRQ, from handshake block |
| drv_rst | output | 1 | Drive RST |
| drv_ack | output | 1 | Drive ACK |
| drv_bsy | output | 1 | Drive BSY |
| drv_sel | output | 1 | Drive SEL |
| drv_atn | output | 1 | Drive ATN |
| drv_data_en | output | 1 | Drive data bus |
| drv_data | output | 8 | Data to drive |
| mode_out | output | 8 | Mode register for neighbours |
| drq | output | 1 | DMA request |
| dma_send_go | output | 1 | Start DMA send pulse |
| dma_trecv_go | output | 1 | Start target DMA receive pulse |
| dma_irecv_go | output | 1 | Start initiator DMA receive pulse |

## Verification
Two things can land on the same clock edge: a processor write to the mode register and the automatic DMA end. The bench provokes this by dropping BSY while DMA is on, in the very cycle it writes a new mode byte with the DMA bit set. The expected result is that the other written bits are kept, the DMA bit reads 0 and end-of-DMA reads 1. A second collision, DRQ set and clear in one cycle, is provoked the same way and is expected to leave DRQ low.

// File: rtl/scsi_ini_regfile.sv
`timescale 1ns/1ps
module scsi_ini_regfile (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] cpu_addr,
  input  logic       cpu_we,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic [7:0] bus_data_in,
  input  logic       bus_rst_in,
  input  logic       bus_bsy_in,
  input  logic       bus_req_in,
  input  logic       bus_msg_in,
  input  logic       bus_cd_in,
  input  logic       bus_io_in,
  input  logic       bus_sel_in,
  input  logic       bus_atn_in,
  input  logic       bus_ack_in,
  input  logic       arb_busy_in,
  input  logic       arb_lost_in,
  input  logic       drq_set_in,
  input  logic       drq_clr_in,
  output logic       drv_rst,
  output logic       drv_ack,
  output logic       drv_bsy,
  output logic       drv_sel,
  output logic       drv_atn,
  output logic       drv_data_en,
  output logic [7:0] drv_data,
  output logic [7:0] mode_out,
  output logic       drq,
  output logic       dma_send_go,
  output logic       dma_trecv_go,
  output logic       dma_irecv_go
);

  logic [7:0] out_q, icmd_q, mode_q, tcmd_q;
  logic       eod_q, drq_q;
  logic       send_q, trecv_q, irecv_q;

  logic [7:0] wr_sel;
  assign wr_sel = cpu_we ? (8'd1 << cpu_addr) : 8'd0;

  logic phase_ok, link_lost;
  assign phase_ok  = ({bus_msg_in, bus_cd_in, bus_io_in} == tcmd_q[2:0]);
  assign link_lost = mode_q[1] & (~bus_bsy_in | ~phase_ok);

  logic [7:0] mode_nxt;
  assign mode_nxt = wr_sel[2] ? cpu_wdata : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= 8'h00;
      icmd_q  <= 8'h00;
      mode_q  <= 8'h00;
      tcmd_q  <= 8'h00;
      eod_q   <= 1'b0;
      drq_q   <= 1'b0;
      send_q  <= 1'b0;
      trecv_q <= 1'b0;
      irecv_q <= 1'b0;
    end else begin
      if (wr_sel[0]) out_q  <= cpu_wdata;
      if (wr_sel[1]) icmd_q <= cpu_wdata & 8'h9F;
      if (wr_sel[3]) tcmd_q <= cpu_wdata;
      mode_q <= link_lost ? (mode_nxt & 8'hFD) : mode_nxt;
      if (link_lost)      eod_q <= 1'b1;
      else if (wr_sel[2]) eod_q <= 1'b0;
      if (link_lost || drq_clr_in)     drq_q <= 1'b0;
      else if (drq_set_in || wr_sel[5]) drq_q <= 1'b1;
      send_q  <= wr_sel[5];
      trecv_q <= wr_sel[6];
      irecv_q <= wr_sel[7];
    end
  end

  assign drv_rst      = icmd_q[7];
  assign drv_ack      = icmd_q[4];
  assign drv_bsy      = icmd_q[3];
  assign drv_sel      = icmd_q[2];
  assign drv_atn      = icmd_q[1];
  assign drv_data_en  = icmd_q[0];
  assign drv_data     = icmd_q[0] ? out_q : 8'h00;
  assign mode_out     = mode_q;
  assign drq          = drq_q;
  assign dma_send_go  = send_q;
  assign dma_trecv_go = trecv_q;
  assign dma_irecv_go = irecv_q;

  always_comb begin
    case (cpu_addr)
      3'd0: cpu_rdata = bus_data_in;
      3'd1: cpu_rdata = icmd_q | {1'b0, arb_busy_in, arb_lost_in, 5'b0};
      3'd2: cpu_rdata = mode_q;
      3'd3: cpu_rdata = tcmd_q;
      3'd4: cpu_rdata = {bus_rst_in, bus_bsy_in, bus_req_in, bus_msg_in,
                         bus_cd_in, bus_io_in, bus_sel_in, 1'b0};
      3'd5: cpu_rdata = {eod_q, drq_q, 2'b00, phase_ok, 1'b0, bus_atn_in, bus_ack_in};
      default: cpu_rdata = 8'h00;
    endcase
  end

  AST_ICMD_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr == 3'd1) |=> (drv_bsy == $past(cpu_wdata[3]) && drv_data_en == $past(cpu_wdata[0]))); // R2
  AST_DMA_END: assert property (@(posedge clk) disable iff (rst)
    (mode_out[1] && (!bus_bsy_in || !phase_ok)) |=> (!mode_out[1] && !drq && cpu_rdata_eod_chk)); // R8
  AST_DRQ_CLR: assert property (@(posedge clk) disable iff (rst)
    drq_clr_in |=> !drq); // R10
  AST_GO_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dma_send_go, dma_trecv_go, dma_irecv_go})); // R11
  AST_RSV_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr == 3'd4) |=> $stable({drv_rst, drv_ack, drv_bsy, drv_sel, drv_atn, drv_data_en, drv_data})); // R12

  logic cpu_rdata_eod_chk;
  assign cpu_rdata_eod_chk = eod_q;

endmodule

// File: tb/scsi_ini_regfile_bench.sv
`timescale 1ns/1ps
module scsi_ini_regfile_bench;
  logic clk = 0, rst = 1;
  logic [2:0] cpu_addr = 0;
  logic cpu_we = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata, bus_data_in = 0;
  logic bus_rst_in = 0, bus_bsy_in = 0, bus_req_in = 0, bus_msg_in = 0, bus_cd_in = 0;
  logic bus_io_in = 0, bus_sel_in = 0, bus_atn_in = 0, bus_ack_in = 0;
  logic arb_busy_in = 0, arb_lost_in = 0, drq_set_in = 0, drq_clr_in = 0;
  logic drv_rst, drv_ack, drv_bsy, drv_sel, drv_atn, drv_data_en, drq;
  logic dma_send_go, dma_trecv_go, dma_irecv_go;
  logic [7:0] drv_data, mode_out;
  int total = 0, bad = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  scsi_ini_regfile u_scsi_ini_regfile (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_we = 1;
    @(negedge clk); cpu_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] r);
    cpu_addr = a; #0.1; r = cpu_rdata;
  endtask

  task automatic set_lines(input logic [7:0] p);
    {bus_rst_in, bus_bsy_in, bus_req_in, bus_msg_in, bus_cd_in, bus_io_in, bus_sel_in, bus_atn_in} = p;
    bus_ack_in = p[5] ^ p[0];
  endtask

  function automatic logic [5:0] drives();
    return {drv_rst, drv_ack, drv_bsy, drv_sel, drv_atn, drv_data_en};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, s;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 drives", {drives(), drv_data, drq}, 15'd0);
    rd(1, r); chk("R1 icmd", r, 0);
    rd(2, r); chk("R1 mode", r, 0);
    rd(3, r); chk("R1 tcmd", r, 0);
    rd(5, r); chk("R1 bas", r, 8'h08);

    wr(0, 8'hA5);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b = v[7:0];
      arb_busy_in = b[2]; arb_lost_in = b[4];
      wr(1, b);
      rd(1, r); chk("R2 icmd read", r, (b & 8'h9F) | {1'b0, b[2], b[4], 5'b0});
      chk("R2 drive lines", drives(), {b[7], b[4], b[3], b[2], b[1], b[0]});
      chk("R3 data gate", drv_data, b[0] ? 8'hA5 : 8'h00);
    end
    arb_busy_in = 0; arb_lost_in = 0;
    wr(1, 8'h01); wr(0, 8'h3C); chk("R3 data update", drv_data, 8'h3C);
    wr(1, 8'h00); chk("R3 data off", drv_data, 8'h00);

    for (int v = 0; v < 256; v++) begin
      bus_data_in = v[7:0]; rd(0, r); chk("R4 data read", r, v);
    end

    for (int v = 0; v < 256; v++) begin
      logic [7:0] p = v[7:0];
      set_lines(p);
      rd(4, r); chk("R5 bus status", r, p & 8'hFE);
      rd(5, r); chk("R6 bas live", r & 8'h0B,
                    {4'b0, p[4:2] == 3'd0, 1'b0, p[0], p[5] ^ p[0]});
    end

    for (int t = 0; t < 8; t++) begin
      wr(3, 8'hF0 | t[7:0]);
      rd(3, r); chk("R13 tcmd read", r, 8'hF0 | t[7:0]);
      for (int ph = 0; ph < 8; ph++) begin
        {bus_msg_in, bus_cd_in, bus_io_in} = ph[2:0];
        rd(5, r); chk("R7 phase match", r[3], (ph == t) ? 1 : 0);
      end
    end

    wr(3, 8'h03); set_lines(8'h40); bus_cd_in = 1; bus_io_in = 1;
    for (int v = 0; v < 256; v++) begin
      wr(2, v[7:0]); rd(2, r); chk("R13 mode read", r, v);
      chk("R13 mode_out", mode_out, v);
    end
    wr(2, 8'h00);

    wr(2, 8'h02);
    @(negedge clk); drq_set_in = 1; @(negedge clk); drq_set_in = 0;
    chk("R10 drq set", drq, 1);
    bus_bsy_in = 0; @(negedge clk);
    rd(2, r); chk("R8 bsy drop mode", r, 8'h00);
    rd(5, r); chk("R8 bsy drop eod", r[7:6], 2'b10);
    bus_bsy_in = 1;
    wr(2, 8'h02); rd(5, r); chk("R9 eod cleared", r[7], 0);
    @(negedge clk); drq_set_in = 1; @(negedge clk); drq_set_in = 0;
    bus_io_in = 0; @(negedge clk);
    rd(2, r); chk("R8 mismatch mode", r, 8'h00);
    rd(5, r); chk("R8 mismatch eod", r[7:6], 2'b10);
    bus_io_in = 1;
    wr(2, 8'h00); rd(5, r); chk("R9 write clears eod", r[7], 0);

    wr(2, 8'h02);
    @(negedge clk); bus_bsy_in = 0; cpu_addr = 2; cpu_wdata = 8'h82; cpu_we = 1;
    @(negedge clk); cpu_we = 0;
    rd(2, r); chk("R9 collision mode", r, 8'h80);
    rd(5, r); chk("R9 collision eod", r[7], 1);
    bus_bsy_in = 1; wr(2, 8'h00);

    @(negedge clk); drq_set_in = 1; drq_clr_in = 1;
    @(negedge clk); drq_set_in = 0; drq_clr_in = 0;
    chk("R10 clear wins", drq, 0);
    wr(5, 8'h00);
    chk("R10 write5 drq", drq, 1);
    chk("R11 send pulse", {dma_send_go, dma_trecv_go, dma_irecv_go}, 3'b100);
    @(negedge clk); chk("R11 send pulse ends", dma_send_go, 0);
    @(negedge clk); drq_clr_in = 1; @(negedge clk); drq_clr_in = 0;
    chk("R10 drq cleared", drq, 0);
    wr(6, 8'h00); chk("R11 trecv pulse", {dma_send_go, dma_trecv_go, dma_irecv_go}, 3'b010);
    wr(7, 8'h00); chk("R11 irecv pulse", {dma_send_go, dma_trecv_go, dma_irecv_go}, 3'b001);
    @(negedge clk); chk("R11 pulses idle", {dma_send_go, dma_trecv_go, dma_irecv_go}, 3'b000);

    wr(0, 8'h5A); wr(1, 8'h1B); wr(2, 8'h44); wr(3, 8'h07);
    rd(6, r); chk("R12 read6", r, 0);
    rd(7, r); chk("R12 read7", r, 0);
    s = drv_data;
    wr(4, 8'hFF);
    rd(1, r); chk("R12 icmd kept", r, 8'h1B);
    rd(2, r); chk("R12 mode kept", r, 8'h44);
    rd(3, r); chk("R12 tcmd kept", r, 8'h07);
    chk("R12 drives kept", {drives(), drv_data}, {6'b011011, s});

    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk("R1 reset again", {drives(), drv_data, drq, mode_out}, 23'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule